// File: doc/BRIEF.md
# Frame Buffer Memory Port Arbiter

This block shares one single-port asynchronous SRAM between two clients in a frame-buffer system. One client is the display refresh engine, which reads pixel words for the video output. The other is the host write path, which stores pixel words into the frame buffer. All decisions are made synchronously to one system clock of nominally 50 MHz. The block drives the SRAM address, the write data, a data-bus drive enable, and the output-enable and write-enable strobes. It returns read data to the display side with a one-cycle valid pulse.

A host write is a level request. The requester holds it, together with its address and data, until the arbiter answers with a one-cycle acknowledge. A pending write always wins over a display read. The write runs as an atomic two-cycle sequence. In the first cycle write-enable is asserted. In the second cycle write-enable is released while the address and data stay on the bus. The acknowledge is raised in that second cycle, and this is the only way a pending write is retired. As a result each request lands exactly once, at the address captured with its data.

Display reads are granted combinationally. The display client advances its address on the clock edge where it sees the grant, so reads can run on every cycle while no write is pending. A display-disable input blocks every refresh read but leaves host writes untouched.

Top module: `fb_sram_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `sram_we`, `sram_oe`, `sram_drive`, `wr_ack` and `rd_valid` are all 0.
- R2: In an idle cycle where `wr_req` is 1, `rd_grant` is 0 even if `rd_req` is 1. The write starts on the next cycle and the read waits.
- R3: A write accepted at an edge drives `sram_we`=1 in the following cycle, with `sram_addr`/`sram_wdata` equal to the `wr_addr`/`wr_data` sampled at that edge. In the cycle after that, `sram_we`=0 and address and data are unchanged. `sram_drive` is 1 in both cycles.
- R4: `wr_ack` is 1 for exactly the second write cycle. The requester drops `wr_req` at that edge. Each request produces exactly one `sram_we` cycle.
- R5: `rd_grant` is 1 in a cycle where `rd_req`=1, `disp_off`=0 and the arbiter is idle with no write pending. In the next cycle `sram_oe`=1 and `sram_addr` equals the granted `rd_addr`.
- R6: One cycle after a cycle with `sram_oe`=1, `rd_valid`=1 and `rd_data` holds the SRAM word read at that address.
- R7: With `rd_req` held, `disp_off`=0 and no write pending, a read is granted on every cycle, so consecutive cycles carry consecutive read addresses.
- R8: While `disp_off`=1, `rd_grant` and `sram_oe` stay 0. Host writes are still carried out.
- R9: `sram_oe` and `sram_we` are never 1 in the same cycle.
- R10: A read pending during a write is granted in the write's second cycle. Its `sram_oe` cycle therefore follows the write with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_off | input | 1 | Display disable; blocks refresh reads |
| wr_req | input | 1 | Host write request, held until `wr_ack` |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write pixel word |
| wr_ack | output | 1 | One-cycle write-complete acknowledge |
| rd_req | input | 1 | Display read request |
| rd_addr | input | ADDR_W | Display read address |
| rd_grant | output | 1 | Read accepted at the coming edge |
| rd_data | output | DATA_W | Returned pixel word |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM read data |
| sram_drive | output | 1 | Drive write data onto the SRAM bus |
| sram_oe | output | 1 | SRAM output enable, active high |
| sram_we | output | 1 | SRAM write enable, active high |

## Verification
The hardest situation to create is a write and a refresh read arriving together. That is the exact point where a write could land twice, land at a stale address, or let a read slip in between its two cycles. The bench holds `rd_req` high with a different address across a whole write. It checks that the grant is withheld in the idle cycle, released only in the second write cycle, and then turns into an `sram_oe` cycle directly after the write. A write-enable counter in the behavioural memory proves that each request produced a single strobe. A read-back sweep that also covers the neighbouring addresses shows that no word went to the wrong place.

// File: rtl/fba_pkg.sv
`timescale 1ns/1ps
package fba_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_WSTROBE = 2'd1,
    PH_WHOLD   = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_t;

  // Pick the bus operation issued at the coming edge.
  function automatic op_t pick_op(input phase_t ph, input logic wr_req,
                                  input logic rd_req, input logic disp_off);
    logic rd_ok;
    rd_ok = rd_req && !disp_off;
    case (ph)
      PH_IDLE:    pick_op = wr_req ? OP_WRITE : (rd_ok ? OP_READ : OP_NONE);
      PH_WHOLD:   pick_op = rd_ok ? OP_READ : OP_NONE;
      default:    pick_op = OP_NONE;
    endcase
  endfunction

  // Phase after the coming edge.
  function automatic phase_t next_phase(input phase_t ph, input op_t op);
    if (ph == PH_WSTROBE)      next_phase = PH_WHOLD;
    else if (op == OP_WRITE)   next_phase = PH_WSTROBE;
    else                       next_phase = PH_IDLE;
  endfunction

endpackage

// File: rtl/fba_sched.sv
`timescale 1ns/1ps
module fba_sched
  import fba_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase,
  input  logic   wr_req,
  input  logic   rd_req,
  input  logic   disp_off,
  output op_t    op,
  output logic   rd_grant
);

  assign op       = pick_op(phase, wr_req, rd_req, disp_off);
  assign rd_grant = (op == OP_READ);

  // R2
  wr_beats_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && wr_req) |-> !rd_grant);

  // R8
  off_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off |-> !rd_grant);

endmodule

// File: rtl/fba_bus.sv
`timescale 1ns/1ps
module fba_bus
  import fba_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_t               op,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output phase_t            phase,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  output logic              sram_we,
  output logic              sram_oe,
  output logic              sram_drive,
  output logic              wr_ack
);

  logic read_issue;
  logic write_start;
  logic write_done;

  assign read_issue  = (op == OP_READ);
  assign write_start = (op == OP_WRITE);
  assign write_done  = (phase == PH_WSTROBE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      sram_addr  <= '0;
      sram_wdata <= '0;
      sram_we    <= 1'b0;
      sram_oe    <= 1'b0;
      sram_drive <= 1'b0;
      wr_ack     <= 1'b0;
    end else begin
      phase <= next_phase(phase, op);
      if (write_done) begin
        sram_we    <= 1'b0;
        sram_oe    <= 1'b0;
        sram_drive <= 1'b1;
        wr_ack     <= 1'b1;
      end else if (write_start) begin
        sram_addr  <= wr_addr;
        sram_wdata <= wr_data;
        sram_we    <= 1'b1;
        sram_oe    <= 1'b0;
        sram_drive <= 1'b1;
        wr_ack     <= 1'b0;
      end else begin
        if (read_issue) sram_addr <= rd_addr;
        sram_we    <= 1'b0;
        sram_oe    <= read_issue;
        sram_drive <= 1'b0;
        wr_ack     <= 1'b0;
      end
    end
  end

  // R9
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_oe && sram_we));

  // R3
  we_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |=> (!sram_we && sram_drive && $stable(sram_addr) && $stable(sram_wdata)));

  // R3
  write_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_start |=> (sram_we && sram_addr == $past(wr_addr) && sram_wdata == $past(wr_data)));

  // R4
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> !wr_ack);

  // R4
  ack_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> ($past(sram_we) && !sram_we));

  // R5
  read_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_issue |=> (sram_oe && sram_addr == $past(rd_addr)));

endmodule

// File: rtl/fba_rdcap.sv
`timescale 1ns/1ps
module fba_rdcap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sram_oe,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= sram_oe;
      if (sram_oe) rd_data <= sram_rdata;
    end
  end

  // R6
  valid_follows_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_oe |=> rd_valid);

  // R6
  valid_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(sram_oe));

endmodule

// File: rtl/fb_sram_arbiter.sv
`timescale 1ns/1ps
module fb_sram_arbiter
  import fba_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_off,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ack,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_grant,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              sram_drive,
  output logic              sram_oe,
  output logic              sram_we
);

  phase_t phase;
  op_t    op;

  fba_sched u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .wr_req   (wr_req),
    .rd_req   (rd_req),
    .disp_off (disp_off),
    .op       (op),
    .rd_grant (rd_grant)
  );

  fba_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .phase      (phase),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata),
    .sram_we    (sram_we),
    .sram_oe    (sram_oe),
    .sram_drive (sram_drive),
    .wr_ack     (wr_ack)
  );

  fba_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk        (clk),
    .rst_n      (rst_n),
    .sram_oe    (sram_oe),
    .sram_rdata (sram_rdata),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

  // R10
  rd_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && rd_grant) |=> sram_oe);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!sram_we && !sram_oe && !wr_ack && !rd_valid && !sram_drive));

endmodule

// File: tb/fb_sram_arbiter_bench.sv
`timescale 1ns/1ps
module fb_sram_arbiter_bench;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NV = 6;

  // stimulus/expected table: write address and word; read back must match
  localparam logic [AW-1:0] T_ADDR [NV] = '{6'd5, 6'd6, 6'd12, 6'd13, 6'd40, 6'd63};
  localparam logic [DW-1:0] T_DATA [NV] = '{8'hA1, 8'h5E, 8'h3C, 8'hC3, 8'h77, 8'hE9};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_off = 1'b0;
  logic wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic wr_ack, rd_grant, rd_valid, sram_drive, sram_oe, sram_we;
  logic [DW-1:0] rd_data, sram_wdata, sram_rdata;
  logic [AW-1:0] sram_addr;

  int checks = 0;
  int fails = 0;
  int we_cnt = 0;
  bit done = 0;
  logic [DW-1:0] mem [64];
  logic [DW-1:0] exp_mem [64];

  always #2.5 clk = ~clk;

  fb_sram_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u_fb_sram_arbiter (
    .clk(clk), .rst_n(rst_n), .disp_off(disp_off),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_grant(rd_grant),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .sram_drive(sram_drive), .sram_oe(sram_oe), .sram_we(sram_we)
  );

  // behavioural asynchronous SRAM
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
    end else if (sram_we) begin
      mem[sram_addr] <= sram_wdata;
      we_cnt <= we_cnt + 1;
    end
  end
  assign sram_rdata = sram_oe ? mem[sram_addr] : '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One host write; optionally a read is held pending across it.
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit with_rd, input logic [AW-1:0] ra);
    int cnt0;
    cnt0 = we_cnt;
    wr_req = 1'b1; wr_addr = a; wr_data = d;
    rd_req = with_rd; rd_addr = ra;
    #1;
    chk("R2 grant withheld while write pending", rd_grant, 0);
    @(negedge clk);
    chk("R3 we cycle1", sram_we, 1);
    chk("R3 addr cycle1", sram_addr, a);
    chk("R3 data cycle1", sram_wdata, d);
    chk("R9 oe off during we", sram_oe, 0);
    chk("R4 no ack in cycle1", wr_ack, 0);
    @(negedge clk);
    chk("R3 we released cycle2", sram_we, 0);
    chk("R3 addr held cycle2", sram_addr, a);
    chk("R3 data held cycle2", sram_wdata, d);
    chk("R3 drive cycle2", sram_drive, 1);
    chk("R4 ack cycle2", wr_ack, 1);
    chk("R10 grant in cycle2", rd_grant, with_rd);
    wr_req = 1'b0;
    @(negedge clk);
    chk("R4 ack single cycle", wr_ack, 0);
    chk("R4 one strobe per write", we_cnt - cnt0, 1);
    exp_mem[a] = d;
    if (with_rd) begin
      chk("R10 read follows write", sram_oe, 1);
      chk("R10 read address", sram_addr, ra);
      rd_req = 1'b0;
      @(negedge clk);
      chk("R6 valid after deferred read", rd_valid, 1);
      chk("R6 data after deferred read", rd_data, exp_mem[ra]);
    end
  endtask

  // Back-to-back reads over a list of addresses.
  task automatic read_burst(input logic [AW-1:0] addrs [8], input int n);
    for (int i = 0; i < n + 2; i++) begin
      if (i >= 1 && i <= n) begin
        chk("R7 oe each cycle", sram_oe, 1);
        chk("R5 read address", sram_addr, addrs[i-1]);
      end
      if (i >= 2) begin
        chk("R6 valid", rd_valid, 1);
        chk("R6 data", rd_data, exp_mem[addrs[i-2]]);
      end
      if (i < n) begin
        rd_req = 1'b1; rd_addr = addrs[i];
        #1;
        chk("R7 grant each cycle", rd_grant, 1);
      end else begin
        rd_req = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] lst [8];
    for (int i = 0; i < 64; i++) exp_mem[i] = '0;
    repeat (4) @(negedge clk);
    chk("R1 we in reset", sram_we, 0);
    chk("R1 oe in reset", sram_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 we after reset", sram_we, 0);
    chk("R1 oe after reset", sram_oe, 0);
    chk("R1 ack after reset", wr_ack, 0);
    chk("R1 valid after reset", rd_valid, 0);
    chk("R1 drive after reset", sram_drive, 0);

    // table walk: writes, every other one with a read held pending
    for (int v = 0; v < NV; v++)
      do_write(T_ADDR[v], T_DATA[v], v[0], T_ADDR[(v + NV - 1) % NV]);

    // read back the table and the untouched neighbours
    for (int v = 0; v < NV; v++) lst[v] = T_ADDR[v];
    lst[6] = 6'd4; lst[7] = 6'd14;
    read_burst(lst, 8);

    // R8: display disabled blocks reads, writes still land
    disp_off = 1'b1; rd_req = 1'b1; rd_addr = 6'd5;
    #1;
    chk("R8 no grant when disabled", rd_grant, 0);
    @(negedge clk);
    chk("R8 no oe when disabled", sram_oe, 0);
    @(negedge clk);
    chk("R8 still no oe", sram_oe, 0);
    chk("R8 no valid", rd_valid, 0);
    rd_req = 1'b0;
    do_write(6'd20, 8'h9D, 1'b0, '0);
    disp_off = 1'b0;
    lst[0] = 6'd20; lst[1] = 6'd21; lst[2] = 6'd19;
    read_burst(lst, 3);

    // overwrite the same address twice; last value must remain
    do_write(6'd40, 8'h11, 1'b1, 6'd63);
    do_write(6'd40, 8'h22, 1'b1, 6'd40);
    lst[0] = 6'd40; lst[1] = 6'd41;
    read_burst(lst, 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule